// File: doc/BRIEF.md
# Serial Bootstrap Program Loader

This block brings a processor core out of reset. It captures a 4-bit boot-mode value at reset and picks one of three paths. In the serial-load path it acts as an SPI slave and collects 24-bit words. The first word is a word count, the second is a load address, and every word after those is program data. The data words are written through a valid/ready write port into consecutive program RAM locations. When the last one is accepted, the loader gives a one-cycle go pulse, and the start-address output then holds the load address. In the ROM path nothing is loaded: the go pulse comes right away, with the start address set to the ROM base. Every other mode value raises a fault flag and the core is never released.

The SPI pins are asynchronous to `clk`. Each one passes through a two-flop synchronizer, so SCK must stay at least three `clk` periods in each level. The write port follows valid/ready rules. When `wr_valid` is high, `wr_addr` and `wr_data` hold steady until a cycle in which `wr_ready` is also high. The loader has one pending word and cannot stall the SPI host. The host must therefore space its words so that each write is accepted before the next word finishes arriving. A word that completes while a write is still pending is dropped.

Top module: `sboot_loader`

## Requirements
- R1: During reset and right after it, `go`, `boot_err` and `wr_valid` are low and `start_addr` reads 0xFFFFFE, the bootstrap vector.
- R2: The mode value is the one on `mode_pins` at the last rising `clk` edge with `rst_n` low. Changes to `mode_pins` after reset do not affect the chosen path.
- R3: SPI uses mode 0. MOSI is sampled on the rising edge of SCK, most significant bit first, and every word is 24 bits. While `spi_ss_n` is high, any partial word is discarded.
- R4: In mode 0000 the first received word is the word count and the second is the load address.
- R5: In mode 0000 each later word is written, in arrival order, to load address + 0, +1, +2 and so on, with the address wrapping modulo 2^24. Exactly count writes take place.
- R6: After the final write is accepted, `go` is high for exactly one cycle, and `start_addr` then equals the load address.
- R7: A count of zero causes no writes, and `go` follows the address word, with `start_addr` equal to that address.
- R8: Mode 0010 issues `go` with `start_addr` = ROM_BASE (default 0x00F000) without any write, and it ignores SPI traffic.
- R9: Every mode other than 0000 and 0010 (including the reserved values 1010 to 1111) sets `boot_err` high. In those modes `go` never pulses and no write is made.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R11: After `go`, further SPI words cause no writes and no second `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 4 | Boot-mode value, captured at reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | SPI data in |
| spi_ss_n | input | 1 | SPI slave select, active low |
| wr_valid | output | 1 | Program RAM write request |
| wr_ready | input | 1 | Program RAM accepts the write |
| wr_addr | output | 24 | Program RAM write address |
| wr_data | output | 24 | Program RAM write data |
| go | output | 1 | One-cycle release pulse for the core |
| start_addr | output | 24 | Execution start address |
| boot_err | output | 1 | Unsupported or reserved boot mode |

## Verification
A four-word load with data words 0x800001, 0xFFFFFF, 0x000000 and 0xA5A5A5 is used to separate bit order, word framing and ordering mistakes. A three-word load at 0xFFFFFE with periodic `wr_ready` stalls checks that the address wraps and that the write port holds steady under back-pressure. Other runs cover a zero count, a ROM jump, reserved and unimplemented modes, mode pins that change after reset, a partial word aborted by raising slave select, and traffic sent after release. Together these separate the count handling, the start-address choice and the fault gating from one another.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

  typedef enum logic [1:0] {
    PATH_LOAD,
    PATH_ROM,
    PATH_FAULT
  } boot_path_t;

  typedef enum logic [2:0] {
    ST_CHECK,
    ST_COUNT,
    ST_ADDR,
    ST_DATA,
    ST_WRITE,
    ST_GO,
    ST_DONE,
    ST_FAULT
  } seq_state_t;

  localparam logic [3:0] MODE_SERIAL_LOAD = 4'b0000;
  localparam logic [3:0] MODE_ROM_JUMP    = 4'b0010;

endpackage

// File: rtl/sboot_mode_latch.sv
module sboot_mode_latch
  import sboot_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  output boot_path_t        path
);

  logic [MODE_W-1:0] mode_q;

  // Keep following the pins while reset is low; hold the value afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pins;
  end

  always_comb begin
    if (mode_q == MODE_W'(MODE_SERIAL_LOAD))   path = PATH_LOAD;
    else if (mode_q == MODE_W'(MODE_ROM_JUMP)) path = PATH_ROM;
    else                                       path = PATH_FAULT;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R2

endmodule

// File: rtl/sboot_spi_rx.sv
module sboot_spi_rx #(
  parameter int WORD_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_N:0]   sck_sy;
  logic [SYNC_N-1:0] mosi_sy;
  logic [SYNC_N-1:0] ssn_sy;
  logic              sck_rise, mosi_b, ssn_b;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      mosi_sy <= '0;
      ssn_sy  <= '1;
    end else begin
      sck_sy  <= {sck_sy[SYNC_N-1:0], spi_sck};
      mosi_sy <= {mosi_sy[SYNC_N-2:0], spi_mosi};
      ssn_sy  <= {ssn_sy[SYNC_N-2:0], spi_ss_n};
    end
  end

  assign sck_rise = sck_sy[SYNC_N-1] & ~sck_sy[SYNC_N];
  assign mosi_b   = mosi_sy[SYNC_N-1];
  assign ssn_b    = ssn_sy[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (ssn_b) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[WORD_W-2:0], mosi_b};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          word_valid <= 1'b1;
          word       <= {shreg[WORD_W-2:0], mosi_b};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ssn_b |=> (bit_cnt == '0)); // R3

  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R3

endmodule

// File: rtl/sboot_seq.sv
module sboot_seq
  import sboot_pkg::*;
#(
  parameter int          WORD_W   = 24,
  parameter int          ADDR_W   = 24,
  parameter logic [23:0] ROM_BASE = 24'h00F000,
  parameter logic [23:0] BOOT_VEC = 24'hFFFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  boot_path_t        path,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              go,
  output logic [ADDR_W-1:0] start_addr,
  output logic              boot_err
);

  seq_state_t        state;
  logic [WORD_W-1:0] remain;
  logic [ADDR_W-1:0] load_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_CHECK;
      remain     <= '0;
      load_addr  <= '0;
      wr_addr    <= '0;
      wr_data    <= '0;
      start_addr <= ADDR_W'(BOOT_VEC);
    end else begin
      unique case (state)
        ST_CHECK: begin
          if (path == PATH_LOAD) begin
            state <= ST_COUNT;
          end else if (path == PATH_ROM) begin
            start_addr <= ADDR_W'(ROM_BASE);
            state      <= ST_GO;
          end else begin
            state <= ST_FAULT;
          end
        end
        ST_COUNT: if (word_valid) begin
          remain <= word;
          state  <= ST_ADDR;
        end
        ST_ADDR: if (word_valid) begin
          load_addr <= word[ADDR_W-1:0];
          wr_addr   <= word[ADDR_W-1:0];
          if (remain == '0) begin
            start_addr <= word[ADDR_W-1:0];
            state      <= ST_GO;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_DATA: if (word_valid) begin
          wr_data <= word;
          state   <= ST_WRITE;
        end
        ST_WRITE: if (wr_ready) begin
          wr_addr <= wr_addr + 1'b1;
          remain  <= remain - 1'b1;
          if (remain == WORD_W'(1)) begin
            start_addr <= load_addr;
            state      <= ST_GO;
          end else begin
            state <= ST_DATA;
          end
        end
        ST_GO:    state <= ST_DONE;
        ST_DONE:  state <= ST_DONE;
        ST_FAULT: state <= ST_FAULT;
        default:  state <= ST_FAULT;
      endcase
    end
  end

  assign wr_valid = (state == ST_WRITE);
  assign go       = (state == ST_GO);
  assign boot_err = (state == ST_FAULT);

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go); // R6

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |=> boot_err && !go && !wr_valid); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R10

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> !wr_valid && !go && $stable(start_addr)); // R11

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && state == ST_WRITE) |=> wr_addr == $past(wr_addr) + 1'b1); // R5

endmodule

// File: rtl/sboot_loader.sv
module sboot_loader
  import sboot_pkg::*;
#(
  parameter int          MODE_W   = 4,
  parameter int          WORD_W   = 24,
  parameter int          ADDR_W   = 24,
  parameter logic [23:0] ROM_BASE = 24'h00F000,
  parameter logic [23:0] BOOT_VEC = 24'hFFFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              go,
  output logic [ADDR_W-1:0] start_addr,
  output logic              boot_err
);

  boot_path_t        path;
  logic              rx_valid;
  logic [WORD_W-1:0] rx_word;

  sboot_mode_latch #(.MODE_W(MODE_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pins (mode_pins),
    .path      (path)
  );

  sboot_spi_rx #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .spi_ss_n   (spi_ss_n),
    .word_valid (rx_valid),
    .word       (rx_word)
  );

  sboot_seq #(
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .ROM_BASE (ROM_BASE),
    .BOOT_VEC (BOOT_VEC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .path       (path),
    .word_valid (rx_valid),
    .word       (rx_word),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .go         (go),
    .start_addr (start_addr),
    .boot_err   (boot_err)
  );

  AST_ERR_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && boot_err)); // R9

endmodule

// File: tb/sim_sboot_loader.sv
`timescale 1ns/1ps
module sim_sboot_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_pins = 4'b0000;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_ss_n = 1'b1;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [23:0] wr_addr;
  logic [23:0] wr_data;
  logic        go;
  logic [23:0] start_addr;
  logic        boot_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_on = 1'b0;

  logic [23:0] cap_a [16];
  logic [23:0] cap_d [16];
  int          wn = 0;
  int          go_n = 0;
  logic [23:0] go_a = '0;
  int          hold_bad = 0;
  bit          prev_stall = 1'b0;
  logic [23:0] prev_a = '0, prev_d = '0;
  logic [23:0] tx [16];

  always #2.5 clk = ~clk;

  sboot_loader u0 (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .go(go), .start_addr(start_addr), .boot_err(boot_err)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (wn < 16) begin cap_a[wn] = wr_addr; cap_d[wn] = wr_data; end
        wn = wn + 1;
      end
      if (go) begin go_n = go_n + 1; go_a = start_addr; end
      if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
        hold_bad = hold_bad + 1;
      prev_stall = wr_valid && !wr_ready;
      prev_a = wr_addr;
      prev_d = wr_data;
    end
  end

  always @(negedge clk) wr_ready = stall_on ? ((cyc % 4) == 3) : 1'b1;

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] m, input logic [3:0] after_m);
    rst_n = 1'b0;
    mode_pins = m;
    spi_ss_n = 1'b1;
    spi_sck = 1'b0;
    repeat (4) @(negedge clk);
    wn = 0; go_n = 0; go_a = '0; hold_bad = 0; prev_stall = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    mode_pins = after_m;
  endtask

  task automatic spi_bit(input logic b);
    spi_mosi = b;
    repeat (4) @(negedge clk);
    spi_sck = 1'b1;
    repeat (4) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic spi_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) spi_bit(w[i]);
  endtask

  task automatic send_tx(input int n);
    spi_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) spi_word(tx[i]);
    repeat (8) @(negedge clk);
    spi_ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    mode_pins = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1", "go in reset", {31'd0, go}, 32'd0);
    chk("R1", "boot_err in reset", {31'd0, boot_err}, 32'd0);
    chk("R1", "wr_valid in reset", {31'd0, wr_valid}, 32'd0);
    chk("R1", "start_addr in reset", {8'd0, start_addr}, 32'h00FFFFFE);
    do_reset(4'b0000, 4'b0000);
    repeat (4) @(negedge clk);
    chk("R1", "start_addr after reset", {8'd0, start_addr}, 32'h00FFFFFE);
    chk("R1", "go after reset", {31'd0, go}, 32'd0);
  endtask

  task automatic t_load;
    logic [23:0] exp_d [4];
    exp_d[0] = 24'h800001; exp_d[1] = 24'hFFFFFF; exp_d[2] = 24'h000000; exp_d[3] = 24'hA5A5A5;
    do_reset(4'b0000, 4'b0000);
    tx[0] = 24'd4; tx[1] = 24'h000100;
    for (int i = 0; i < 4; i++) tx[i+2] = exp_d[i];
    send_tx(6);
    chk("R5", "write count", wn, 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R5", "write address", {8'd0, cap_a[i]}, 32'h100 + i);
      chk("R3", "write data bit order", {8'd0, cap_d[i]}, {8'd0, exp_d[i]});
    end
    chk("R6", "go pulses", go_n, 32'd1);
    chk("R4", "start address = load address", {8'd0, go_a}, 32'h000100);
    chk("R6", "start_addr held", {8'd0, start_addr}, 32'h000100);
    tx[0] = 24'h123456; tx[1] = 24'h654321;
    send_tx(2);
    chk("R11", "writes after go", wn, 32'd4);
    chk("R11", "go pulses after go", go_n, 32'd1);
  endtask

  task automatic t_stall;
    do_reset(4'b0000, 4'b0000);
    stall_on = 1'b1;
    tx[0] = 24'd3; tx[1] = 24'hFFFFFE;
    tx[2] = 24'h111111; tx[3] = 24'h222222; tx[4] = 24'h333333;
    send_tx(5);
    stall_on = 1'b0;
    chk("R5", "stalled write count", wn, 32'd3);
    chk("R5", "wrap addr 0", {8'd0, cap_a[0]}, 32'h00FFFFFE);
    chk("R5", "wrap addr 1", {8'd0, cap_a[1]}, 32'h00FFFFFF);
    chk("R5", "wrap addr 2", {8'd0, cap_a[2]}, 32'h00000000);
    chk("R5", "stalled data 2", {8'd0, cap_d[2]}, 32'h00333333);
    chk("R10", "hold violations", hold_bad, 32'd0);
    chk("R6", "go at load address", {8'd0, go_a}, 32'h00FFFFFE);
  endtask

  task automatic t_zero;
    do_reset(4'b0000, 4'b0000);
    tx[0] = 24'd0; tx[1] = 24'h001234;
    send_tx(2);
    chk("R7", "zero count writes", wn, 32'd0);
    chk("R7", "zero count go", go_n, 32'd1);
    chk("R7", "zero count start", {8'd0, go_a}, 32'h001234);
  endtask

  task automatic t_rom;
    do_reset(4'b0010, 4'b0000);
    repeat (10) @(negedge clk);
    chk("R8", "rom go", go_n, 32'd1);
    chk("R8", "rom start", {8'd0, go_a}, 32'h00F000);
    tx[0] = 24'd1; tx[1] = 24'h000200; tx[2] = 24'hABCDEF;
    send_tx(3);
    chk("R8", "rom writes", wn, 32'd0);
    chk("R8", "rom err", {31'd0, boot_err}, 32'd0);
  endtask

  task automatic t_err(input logic [3:0] m);
    do_reset(m, 4'b0000);
    repeat (6) @(negedge clk);
    chk("R9", "fault flag", {31'd0, boot_err}, 32'd1);
    tx[0] = 24'd1; tx[1] = 24'h000300; tx[2] = 24'h0F0F0F;
    send_tx(3);
    chk("R9", "fault go", go_n, 32'd0);
    chk("R9", "fault writes", wn, 32'd0);
    chk("R9", "fault flag held", {31'd0, boot_err}, 32'd1);
  endtask

  task automatic t_abort;
    do_reset(4'b0000, 4'b0010);
    repeat (3) @(negedge clk);
    mode_pins = 4'b1111;
    chk("R2", "no go after pin change", go_n, 32'd0);
    chk("R2", "no fault after pin change", {31'd0, boot_err}, 32'd0);
    spi_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) spi_bit(1'b1);
    repeat (8) @(negedge clk);
    spi_ss_n = 1'b1;
    repeat (8) @(negedge clk);
    tx[0] = 24'd1; tx[1] = 24'h000040; tx[2] = 24'h123456;
    send_tx(3);
    chk("R3", "partial word discarded count", wn, 32'd1);
    chk("R3", "partial word discarded data", {8'd0, cap_d[0]}, 32'h00123456);
    chk("R2", "loaded path kept", {8'd0, go_a}, 32'h000040);
  endtask

  initial begin
    t_reset();
    t_load();
    t_stall();
    t_zero();
    t_rom();
    t_err(4'b1010);
    t_err(4'b1111);
    t_err(4'b0001);
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule